// File: doc/BRIEF.md
# Register-Loaded Command Sequencer

This block is the software-control front end of a content-addressable memory. It sits between the host bus and the execution unit. It decides, cycle by cycle, which 12-bit command code is handed to that unit and whether the command is read-type or write-type. In hardware-control mode the code comes straight from a dedicated 12-bit control bus, and the write strobe gives the read/write qualifier. When every bit of the control-mode configuration field is HIGH, the control bus is ignored. Commands are then taken from the data bus during write cycles that do not carry a valid address.

A command taken from the data bus falls into one of two kinds. Immediate commands are issued in the same cycle they are captured. Deferred commands are the ones that move data across the 32-bit bus. They are held and issued on every later address-valid data cycle until another command is captured. A read cycle without a valid address selects the status register and issues nothing. While a held memory access is issued, a validity output passes on the valid bit of the location being accessed.

Top module: `cam_cmd_seq`

## Requirements
- R1: When `ctl_mode_i` is not all ones, every bus cycle that is not a status read issues `ctl_i` on `cmd_code_o`, with `exec_o`=1 and `cmd_rd_o`=~`we_i`. Data-bus contents are not captured.
- R2: When `ctl_mode_i` is all ones, a bus cycle with `av_n_i`=1 and `we_i`=1 captures `data_i[11:0]` as the command code. `ctl_i` has no effect.
- R3: In a capture cycle, `data_i[12]` is the qualifier: 0 gives a write-type command (`cmd_rd_o`=0) and 1 gives a read-type command (`cmd_rd_o`=1).
- R4: A captured code whose class field (code bits 11:8) lies outside 1..5 is immediate. `exec_o`=1 in the capture cycle itself, with that code and `cmd_xfer_o`=0.
- R5: A captured code of class 1 (memory access), 2 (register access), 3 (validity read), 4 (page-address write) or 5 (set full flag) is deferred. `exec_o`=0 in the capture cycle. The next bus cycle with `av_n_i`=0 issues it with `cmd_xfer_o`=1.
- R6: A held deferred command is issued again on every later bus cycle with `av_n_i`=0 until a new capture. After an immediate capture, `av_n_i`=0 cycles issue nothing.
- R7: A bus cycle with `av_n_i`=1 and `we_i`=0 raises `stat_rd_o` and leaves `exec_o`=0, in both modes.
- R8: `vld_o` equals `loc_vld_i` while a held class 1 or class 3 command is issued. It is 0 otherwise.
- R9: After reset the held command is the no-operation code 0x000 (write-type). Data cycles in register mode issue nothing until a deferred command is captured.
- R10: With `cyc_i`=0, `exec_o`, `stat_rd_o` and `vld_o` are 0 and the held command is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_mode_i | input | 2 | Control-mode field; all ones selects register control |
| cyc_i | input | 1 | A bus cycle is present this clock |
| av_n_i | input | 1 | Address-valid strobe, active low |
| we_i | input | 1 | 1 = write cycle, 0 = read cycle |
| data_i | input | 32 | Host data bus |
| ctl_i | input | 12 | Dedicated control bus |
| loc_vld_i | input | 1 | Valid bit of the accessed location from the array |
| exec_o | output | 1 | Issue pulse to the execution unit |
| cmd_code_o | output | 12 | Issued command code |
| cmd_rd_o | output | 1 | Issued qualifier, 1 = read-type |
| cmd_xfer_o | output | 1 | Issued command moves data on the bus |
| stat_rd_o | output | 1 | Status-register read select |
| vld_o | output | 1 | Validity of the accessed location |

## Verification
The bench first drives the control bus and the data bus with different values in hardware mode. This shows which source feeds the code and that nothing is captured. In register mode it captures codes on each side of the deferred class range: class 0, 5 and 6, and 7 with both qualifier values. This tells the immediate path apart from the held path. It then runs repeated data cycles, interleaved with idle cycles and status reads. These show persistence, replacement by a later capture, and the validity pass-through being limited to memory-class commands.

// File: rtl/cam_cmd_pkg.sv
package cam_cmd_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned CLS_W  = 4;

  typedef struct packed {
    logic              rd;
    logic [CODE_W-1:0] code;
  } cmd_t;

  localparam cmd_t CMD_NOP = '{rd: 1'b0, code: '0};

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM  = 4'd1,
    CLS_REG  = 4'd2,
    CLS_VLD  = 4'd3,
    CLS_PAGE = 4'd4,
    CLS_FULL = 4'd5
  } cmd_cls_e;

  function automatic logic [CLS_W-1:0] cls_of(input logic [CODE_W-1:0] c);
    return c[CODE_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
  import cam_cmd_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              deferred_o,
  output logic              mem_o
);
  logic [CLS_W-1:0] cls;

  always_comb begin
    cls        = cls_of(code_i);
    deferred_o = 1'b0;
    mem_o      = 1'b0;
    unique case (cls)
      CLS_MEM, CLS_VLD: begin
        deferred_o = 1'b1;
        mem_o      = 1'b1;
      end
      CLS_REG, CLS_PAGE, CLS_FULL: deferred_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (mem_o) assert (deferred_o) else $error("AST_MEM_IS_DEFERRED"); // R8
  end
endmodule

// File: rtl/cam_cmd_hold.sv
module cam_cmd_hold
  import cam_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cmd_t cmd_i,
  output cmd_t held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_o <= CMD_NOP;
    else if (load_i) held_o <= cmd_i;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(held_o)) else $error("AST_HOLD_STABLE"); // R6
  AST_HOLD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> held_o == $past(cmd_i)) else $error("AST_HOLD_LOAD"); // R2
endmodule

// File: rtl/cam_cmd_issue.sv
module cam_cmd_issue
  import cam_cmd_pkg::*;
(
  input  logic              cyc_i,
  input  logic              sw_mode_i,
  input  logic              av_n_i,
  input  logic              we_i,
  input  cmd_t              cap_cmd_i,
  input  logic              cap_def_i,
  input  logic [CODE_W-1:0] ctl_i,
  input  cmd_t              held_i,
  input  logic              held_def_i,
  input  logic              held_mem_i,
  input  logic              loc_vld_i,
  output logic              exec_o,
  output cmd_t              cmd_o,
  output logic              xfer_o,
  output logic              stat_o,
  output logic              vld_o
);
  always_comb begin
    exec_o = 1'b0;
    cmd_o  = CMD_NOP;
    xfer_o = 1'b0;
    stat_o = 1'b0;
    vld_o  = 1'b0;
    if (cyc_i) begin
      if (av_n_i && !we_i) begin
        stat_o = 1'b1;
      end else if (!sw_mode_i) begin
        exec_o = 1'b1;
        cmd_o  = '{rd: !we_i, code: ctl_i};
      end else if (av_n_i) begin
        // capture cycle: only immediate commands run now
        exec_o = !cap_def_i;
        cmd_o  = cap_cmd_i;
      end else begin
        exec_o = held_def_i;
        cmd_o  = held_i;
        xfer_o = held_def_i;
        vld_o  = held_mem_i & loc_vld_i;
      end
    end
  end

  always_comb begin
    assert ($onehot0({exec_o, stat_o})) else $error("AST_EXEC_XOR_STAT"); // R7
    if (vld_o) assert (xfer_o) else $error("AST_VLD_NEEDS_XFER"); // R8
  end
endmodule

// File: rtl/cam_cmd_seq.sv
module cam_cmd_seq
  import cam_cmd_pkg::*;
#(
  parameter int unsigned MODE_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] ctl_mode_i,
  input  logic              cyc_i,
  input  logic              av_n_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CODE_W-1:0] ctl_i,
  input  logic              loc_vld_i,
  output logic              exec_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic              cmd_rd_o,
  output logic              cmd_xfer_o,
  output logic              stat_rd_o,
  output logic              vld_o
);
  localparam int unsigned QUAL_BIT = CODE_W;

  logic sw_mode, load, cap_def, cap_mem, held_def, held_mem;
  cmd_t cap_cmd, held, issued;

  assign sw_mode = &ctl_mode_i;
  assign cap_cmd = '{rd: data_i[QUAL_BIT], code: data_i[CODE_W-1:0]};
  assign load    = cyc_i & sw_mode & av_n_i & we_i;

  cam_cmd_decode u_dec_cap (
    .code_i(cap_cmd.code), .deferred_o(cap_def), .mem_o(cap_mem)
  );
  cam_cmd_decode u_dec_held (
    .code_i(held.code), .deferred_o(held_def), .mem_o(held_mem)
  );

  cam_cmd_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .cmd_i(cap_cmd), .held_o(held)
  );

  cam_cmd_issue u_issue (
    .cyc_i(cyc_i), .sw_mode_i(sw_mode), .av_n_i(av_n_i), .we_i(we_i),
    .cap_cmd_i(cap_cmd), .cap_def_i(cap_def), .ctl_i(ctl_i),
    .held_i(held), .held_def_i(held_def), .held_mem_i(held_mem),
    .loc_vld_i(loc_vld_i), .exec_o(exec_o), .cmd_o(issued),
    .xfer_o(cmd_xfer_o), .stat_o(stat_rd_o), .vld_o(vld_o)
  );

  assign cmd_code_o = issued.code;
  assign cmd_rd_o   = issued.rd;

  AST_DEFER_NO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && cap_def) |-> !exec_o) else $error("AST_DEFER_NO_EXEC"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |-> !(exec_o || stat_rd_o || vld_o)) else $error("AST_IDLE_QUIET"); // R10
  AST_HW_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_mode |=> $stable(held)) else $error("AST_HW_NO_LOAD"); // R1
  AST_XFER_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_xfer_o |-> (sw_mode && !av_n_i && exec_o)) else $error("AST_XFER_SW_ONLY"); // R6
endmodule

// File: tb/cam_cmd_seq_bench.sv
module cam_cmd_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ctl_mode_i = 2'b00;
  logic        cyc_i = 1'b0, av_n_i = 1'b1, we_i = 1'b0, loc_vld_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [11:0] ctl_i = '0;
  logic        exec_o, cmd_rd_o, cmd_xfer_o, stat_rd_o, vld_o;
  logic [11:0] cmd_code_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  cam_cmd_seq u_cam_cmd_seq (
    .clk_i, .rst_ni, .ctl_mode_i, .cyc_i, .av_n_i, .we_i, .data_i, .ctl_i,
    .loc_vld_i, .exec_o, .cmd_code_o, .cmd_rd_o, .cmd_xfer_o, .stat_rd_o, .vld_o
  );

  // drive at negedge, compare 1 ns later, then let the posedge update state
  task automatic step(input string req, input logic cyc, input logic avn,
                      input logic we, input logic [31:0] d, input logic [11:0] c,
                      input logic lv, input logic e_exec, input logic [11:0] e_code,
                      input logic e_rd, input logic e_xfer, input logic e_stat,
                      input logic e_vld);
    @(negedge clk_i);
    cyc_i = cyc; av_n_i = avn; we_i = we; data_i = d; ctl_i = c; loc_vld_i = lv;
    #1;
    n_chk++;
    if (exec_o !== e_exec || stat_rd_o !== e_stat || vld_o !== e_vld ||
        cmd_xfer_o !== e_xfer ||
        (e_exec && (cmd_code_o !== e_code || cmd_rd_o !== e_rd))) begin
      n_fail++;
      $display("FAIL %s: got exec=%b code=%h rd=%b xfer=%b stat=%b vld=%b exp exec=%b code=%h rd=%b xfer=%b stat=%b vld=%b",
               req, exec_o, cmd_code_o, cmd_rd_o, cmd_xfer_o, stat_rd_o, vld_o,
               e_exec, e_code, e_rd, e_xfer, e_stat, e_vld);
    end
  endtask

  task automatic t_reset;
    ctl_mode_i = 2'b11;
    step("R10", 0, 0, 1, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R9",  1, 0, 1, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R9",  1, 0, 0, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
  endtask

  task automatic t_hw;
    ctl_mode_i = 2'b01;
    step("R1", 1, 0, 1, 32'h0000_0123, 12'h3C4, 0, 1, 12'h3C4, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 32'h0, 12'h0F0, 0, 1, 12'h0F0, 1, 0, 0, 0);
    // data-bus write that would load a deferred command in register mode
    step("R1", 1, 1, 1, 32'h0000_1155, 12'h222, 0, 1, 12'h222, 0, 0, 0, 0);
    step("R7", 1, 1, 0, 32'h0, 12'h777, 0, 0, 12'h0, 0, 0, 1, 0);
    ctl_mode_i = 2'b10;
    step("R1", 1, 0, 1, 32'h0, 12'h5A5, 0, 1, 12'h5A5, 0, 0, 0, 0);
    ctl_mode_i = 2'b11;
    step("R1", 1, 0, 1, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
  endtask

  task automatic t_imm;
    ctl_mode_i = 2'b11;
    step("R3", 1, 1, 1, 32'hFFFF_1723, 12'hFFF, 0, 1, 12'h723, 1, 0, 0, 0);
    step("R3", 1, 1, 1, 32'h0000_0723, 12'h000, 0, 1, 12'h723, 0, 0, 0, 0);
    step("R4", 1, 1, 1, 32'h0000_0600, 12'h111, 0, 1, 12'h600, 0, 0, 0, 0);
    step("R4", 1, 1, 1, 32'h0000_10FF, 12'h111, 0, 1, 12'h0FF, 1, 0, 0, 0);
    step("R6", 1, 0, 1, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
  endtask

  task automatic t_defer;
    ctl_mode_i = 2'b11;
    step("R5", 1, 1, 1, 32'h0000_0123, 12'hABC, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R5", 1, 0, 1, 32'h0, 12'h0, 1, 1, 12'h123, 0, 1, 0, 1);
    step("R8", 1, 0, 0, 32'h0, 12'h0, 0, 1, 12'h123, 0, 1, 0, 0);
    step("R10", 0, 1, 1, 32'h0000_0AAA, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R6", 1, 0, 1, 32'h0, 12'h0, 1, 1, 12'h123, 0, 1, 0, 1);
    step("R7", 1, 1, 0, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 1, 0);
    step("R6", 1, 0, 0, 32'h0, 12'h0, 1, 1, 12'h123, 0, 1, 0, 1);
    step("R5", 1, 1, 1, 32'h0000_12AB, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 32'h0, 12'h0, 1, 1, 12'h2AB, 1, 1, 0, 0);
    step("R5", 1, 1, 1, 32'h0000_0500, 12'h0, 0, 0, 12'h0, 0, 0, 0, 0);
    step("R5", 1, 0, 1, 32'h0, 12'h0, 1, 1, 12'h500, 0, 1, 0, 0);
    step("R8", 1, 1, 1, 32'h0000_1301, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 32'h0, 12'h0, 1, 1, 12'h301, 1, 1, 0, 1);
    step("R6", 1, 1, 1, 32'h0000_0042, 12'h0, 1, 1, 12'h042, 0, 0, 0, 0);
    step("R6", 1, 0, 1, 32'h0, 12'h0, 1, 0, 12'h0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_hw();
    t_imm();
    t_defer();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule